// File: doc/BRIEF.md
# Four-Channel Scatter-Gather DMA Engine

This block is a bus-master DMA engine with four independent channels. It moves data memory-to-memory, memory-to-peripheral or peripheral-to-memory over a single request/grant master port. Every transfer unit is one word. The engine reads the word into an internal buffer, then writes it out in a separate bus access. It re-arbitrates among the ready channels after each unit, and channel 0 has the highest priority.

Software programs each channel through a write-only configuration port that holds four registers: control, source, destination and count. In scatter-gather mode the channel does not use its register values directly. It walks a chain of five-word descriptors in memory, loading a new transfer from each one, until it reaches a descriptor whose next pointer is zero. Peripheral-side accesses are paced by a per-channel request/acknowledge pair. Completion is reported by a per-channel terminal-count flag and a combined interrupt.

Top module: `sgdma`

## Requirements
- R1: The configuration write (`cfg_we`, `cfg_ch`, `cfg_sel`) selects a register by `cfg_sel`: 0 is control, 1 is source, 2 is destination, 3 is count. The control bit fields are: bit 0 go, bits 2:1 source mode, bits 4:3 destination mode, bits 6:5 direction, bit 7 interrupt enable, bit 8 scatter-gather. Writing control to an idle channel clears its terminal-count flag. If go is 1, the same write also starts the channel.
- R2: Each unit is a read of the source word into the internal buffer, followed by a write of that word to the destination. While `m_req` is high without `m_gnt`, the signals `m_addr`, `m_we` and `m_wdata` hold steady into the next cycle.
- R3: Source and destination each have their own 2-bit mode. Mode 00 increments the address by one after every unit, 01 decrements it by one, and 10 or 11 holds it.
- R4: The count gives the number of units to move. Starting a channel with count 0 (not in scatter-gather mode) sets its terminal-count flag without any bus access.
- R5: Direction 00 (and 11) is memory-to-memory and is not paced. Direction 01 is memory-to-peripheral and direction 10 is peripheral-to-memory. For both of these, a unit starts only while the channel's `dreq` bit is high. `dack` pulses once per unit, in the cycle the peripheral-side access is granted: the write for 01, the read for 10.
- R6: Channels are served in fixed priority with channel 0 highest, and the choice is made again before every unit.
- R7: When a channel is started in scatter-gather mode, its source register gives the address of the first descriptor. Descriptor words are, by offset: +0 source, +1 destination, +2 count, +3 control (modes, direction and interrupt enable taken from it), +4 next pointer. A nonzero next pointer chains to the next descriptor, and a descriptor with count 0 moves nothing.
- R8: When the last unit of a channel completes, `tc` for that channel is set. `irq` is high while any channel has both `tc` set and its interrupt enable set.
- R9: Register writes to an active channel are ignored.
- R10: At most one `dack` bit is high, and only in a granted cycle.
- R11: After reset, `m_req`, `tc`, `dack` and `irq` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_ch | input | CHW | Channel addressed by the write |
| cfg_sel | input | 2 | Register select |
| cfg_wdata | input | DW | Register write data |
| m_req | output | 1 | Master request |
| m_we | output | 1 | Master write (1) or read (0) |
| m_addr | output | AW | Master word address |
| m_wdata | output | DW | Master write data |
| m_gnt | input | 1 | Master grant; the access completes this cycle |
| m_rdata | input | DW | Read data, valid with the grant |
| dreq | input | NCH | Peripheral request per channel |
| dack | output | NCH | Peripheral acknowledge per channel |
| tc | output | NCH | Terminal-count flags |
| irq | output | 1 | Interrupt |

## Verification
The bench sweeps every pairing of source and destination address modes and compares the whole memory against an arithmetic replay. A design with an off-by-one step or a swapped mode would leave corrupted or misplaced words. Zero-count starts, a zero-count descriptor in the middle of a chain, and a chain that ends on a null pointer are all exercised. An engine that moved a unit on count 0, or followed the null pointer, would change memory outside the expected regions. Paced channels are held back with `dreq` low while their registers are rewritten. An engine that ignored pacing, or accepted writes while busy, would either move data early or copy the wrong region. Two channels released in the same cycle, and a low-numbered channel started in the middle of another channel's transfer, expose priority errors and missing per-unit re-arbitration in the logged write order.

// File: rtl/sgdma.sv
module sgdma #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 32,
  parameter int CW  = 16,
  localparam int CHW = (NCH > 1) ? $clog2(NCH) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic [CHW-1:0] cfg_ch,
  input  logic [1:0]     cfg_sel,
  input  logic [DW-1:0]  cfg_wdata,
  output logic           m_req,
  output logic           m_we,
  output logic [AW-1:0]  m_addr,
  output logic [DW-1:0]  m_wdata,
  input  logic           m_gnt,
  input  logic [DW-1:0]  m_rdata,
  input  logic [NCH-1:0] dreq,
  output logic [NCH-1:0] dack,
  output logic [NCH-1:0] tc,
  output logic           irq
);

  typedef enum logic [1:0] {ST_IDLE, ST_RD, ST_WR, ST_DSC} st_t;

  st_t            st_q;
  logic [CHW-1:0] cur_q;
  logic [2:0]     fidx_q;
  logic [DW-1:0]  buf_q;

  logic [AW-1:0]  src_q [NCH];
  logic [AW-1:0]  dst_q [NCH];
  logic [AW-1:0]  nxt_q [NCH];
  logic [CW-1:0]  cnt_q [NCH];
  logic [1:0]     sm_q  [NCH];
  logic [1:0]     dm_q  [NCH];
  logic [1:0]     dir_q [NCH];
  logic [NCH-1:0] ie_q, sg_q, act_q, fch_q, tc_q;

  logic [NCH-1:0] rdy;
  logic [CHW-1:0] pick;
  logic           unused_bits;

  assign unused_bits = ^{cfg_wdata, m_rdata};

  function automatic logic [AW-1:0] step(input logic [AW-1:0] a, input logic [1:0] m);
    case (m)
      2'b00:   step = a + 1'b1;
      2'b01:   step = a - 1'b1;
      default: step = a;
    endcase
  endfunction

  function automatic logic paced(input logic [1:0] d);
    paced = (d == 2'b01) || (d == 2'b10);
  endfunction

  always_comb begin
    for (int c = 0; c < NCH; c++)
      rdy[c] = act_q[c] && (fch_q[c] || !paced(dir_q[c]) || dreq[c]);
    pick = '0;
    for (int c = NCH - 1; c >= 0; c--)
      if (rdy[c]) pick = CHW'(c);
  end

  assign m_req   = (st_q != ST_IDLE);
  assign m_we    = (st_q == ST_WR);
  assign m_wdata = buf_q;
  assign tc      = tc_q;
  assign irq     = |(tc_q & ie_q);

  always_comb begin
    case (st_q)
      ST_DSC:  m_addr = nxt_q[cur_q] + AW'(fidx_q);
      ST_RD:   m_addr = src_q[cur_q];
      ST_WR:   m_addr = dst_q[cur_q];
      default: m_addr = '0;
    endcase
  end

  always_comb begin
    for (int c = 0; c < NCH; c++)
      dack[c] = m_gnt && (cur_q == CHW'(c)) &&
                ((st_q == ST_RD && dir_q[c] == 2'b10) ||
                 (st_q == ST_WR && dir_q[c] == 2'b01));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cur_q  <= '0;
      fidx_q <= '0;
      buf_q  <= '0;
      ie_q   <= '0;
      sg_q   <= '0;
      act_q  <= '0;
      fch_q  <= '0;
      tc_q   <= '0;
      for (int c = 0; c < NCH; c++) begin
        src_q[c] <= '0;
        dst_q[c] <= '0;
        nxt_q[c] <= '0;
        cnt_q[c] <= '0;
        sm_q[c]  <= '0;
        dm_q[c]  <= '0;
        dir_q[c] <= '0;
      end
    end else begin
      if (cfg_we && !act_q[cfg_ch]) begin
        case (cfg_sel)
          2'd0: begin
            sm_q[cfg_ch]  <= cfg_wdata[2:1];
            dm_q[cfg_ch]  <= cfg_wdata[4:3];
            dir_q[cfg_ch] <= cfg_wdata[6:5];
            ie_q[cfg_ch]  <= cfg_wdata[7];
            sg_q[cfg_ch]  <= cfg_wdata[8];
            tc_q[cfg_ch]  <= 1'b0;
            if (cfg_wdata[0]) begin
              if (cfg_wdata[8]) begin
                act_q[cfg_ch] <= 1'b1;
                fch_q[cfg_ch] <= 1'b1;
                nxt_q[cfg_ch] <= src_q[cfg_ch];
              end else if (cnt_q[cfg_ch] == '0) begin
                tc_q[cfg_ch]  <= 1'b1;
              end else begin
                act_q[cfg_ch] <= 1'b1;
              end
            end
          end
          2'd1:    src_q[cfg_ch] <= cfg_wdata[AW-1:0];
          2'd2:    dst_q[cfg_ch] <= cfg_wdata[AW-1:0];
          default: cnt_q[cfg_ch] <= cfg_wdata[CW-1:0];
        endcase
      end

      case (st_q)
        ST_IDLE: begin
          if (|rdy) begin
            cur_q  <= pick;
            fidx_q <= '0;
            st_q   <= fch_q[pick] ? ST_DSC : ST_RD;
          end
        end
        ST_DSC: begin
          if (m_gnt) begin
            fidx_q <= fidx_q + 3'd1;
            case (fidx_q)
              3'd0: src_q[cur_q] <= m_rdata[AW-1:0];
              3'd1: dst_q[cur_q] <= m_rdata[AW-1:0];
              3'd2: cnt_q[cur_q] <= m_rdata[CW-1:0];
              3'd3: begin
                sm_q[cur_q]  <= m_rdata[2:1];
                dm_q[cur_q]  <= m_rdata[4:3];
                dir_q[cur_q] <= m_rdata[6:5];
                ie_q[cur_q]  <= m_rdata[7];
              end
              default: begin
                nxt_q[cur_q] <= m_rdata[AW-1:0];
                st_q         <= ST_IDLE;
                if (cnt_q[cur_q] != '0) begin
                  fch_q[cur_q] <= 1'b0;
                end else if (m_rdata[AW-1:0] == '0) begin
                  fch_q[cur_q] <= 1'b0;
                  act_q[cur_q] <= 1'b0;
                  tc_q[cur_q]  <= 1'b1;
                end
              end
            endcase
          end
        end
        ST_RD: begin
          if (m_gnt) begin
            buf_q <= m_rdata;
            st_q  <= ST_WR;
          end
        end
        default: begin
          if (m_gnt) begin
            src_q[cur_q] <= step(src_q[cur_q], sm_q[cur_q]);
            dst_q[cur_q] <= step(dst_q[cur_q], dm_q[cur_q]);
            cnt_q[cur_q] <= cnt_q[cur_q] - 1'b1;
            st_q         <= ST_IDLE;
            if (cnt_q[cur_q] == CW'(1)) begin
              if (sg_q[cur_q] && nxt_q[cur_q] != '0) begin
                fch_q[cur_q] <= 1'b1;
              end else begin
                act_q[cur_q] <= 1'b0;
                tc_q[cur_q]  <= 1'b1;
              end
            end
          end
        end
      endcase
    end
  end

endmodule

// File: rtl/sgdma_chk.sv
module sgdma_chk #(
  parameter int NCH = 4,
  parameter int AW  = 16,
  parameter int DW  = 32
) (
  input logic           clk,
  input logic           rst_n,
  input logic           m_req,
  input logic           m_we,
  input logic           m_gnt,
  input logic [AW-1:0]  m_addr,
  input logic [DW-1:0]  m_wdata,
  input logic [NCH-1:0] dack,
  input logic [NCH-1:0] tc,
  input logic           irq
);

  // R2
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_req && !m_gnt) |=> (m_req && $stable(m_addr) && $stable(m_we) && $stable(m_wdata)));

  // R10
  dack_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(dack));

  // R10
  dack_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|dack) |-> (m_req && m_gnt));

  // R8
  irq_tc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (|tc));

endmodule

bind sgdma sgdma_chk #(.NCH(NCH), .AW(AW), .DW(DW)) u_sgdma_chk (
  .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_gnt(m_gnt),
  .m_addr(m_addr), .m_wdata(m_wdata), .dack(dack), .tc(tc), .irq(irq)
);

// File: tb/sgdma_bench.sv
module sgdma_bench;
  localparam int NCH = 4, AW = 8, DW = 32, CW = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 1'b0;
  logic [1:0] cfg_ch = '0, cfg_sel = '0;
  logic [DW-1:0] cfg_wdata = '0;
  logic m_req, m_we, m_gnt = 1'b0;
  logic [AW-1:0] m_addr;
  logic [DW-1:0] m_wdata, m_rdata;
  logic [NCH-1:0] dreq = '0, dack, tc;
  logic irq;

  logic [DW-1:0] mem [256];
  logic [DW-1:0] exp_m [256];
  int runs = 0, fails = 0, cyc = 0;
  int dk [NCH];
  logic [AW-1:0] wlog [64];
  int nw = 0;
  bit req_seen = 0;
  bit done = 0;

  always #2 clk = ~clk;

  sgdma #(.NCH(NCH), .AW(AW), .DW(DW), .CW(CW)) u_sgdma (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ch(cfg_ch), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_gnt(m_gnt), .m_rdata(m_rdata), .dreq(dreq), .dack(dack),
    .tc(tc), .irq(irq));

  assign m_rdata = mem[m_addr];

  always @(negedge clk) begin
    cyc <= cyc + 1;
    m_gnt <= (cyc % 3) != 1;
  end

  always @(posedge clk) begin
    if (m_req) req_seen <= 1;
    if (m_req && m_we && m_gnt) begin
      mem[m_addr] <= m_wdata;
      if (nw < 64) wlog[nw] <= m_addr;
      nw <= nw + 1;
    end
    for (int c = 0; c < NCH; c++) if (dack[c]) dk[c] <= dk[c] + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int expv);
    runs++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic logic [DW-1:0] ctl(input bit go, input int sm, input int dm,
                                        input int dir, input bit ie, input bit sg);
    ctl = {23'd0, sg, ie, dir[1:0], dm[1:0], sm[1:0], go};
  endfunction

  function automatic logic [AW-1:0] stp(input logic [AW-1:0] a, input int m);
    stp = (m == 0) ? a + 1'b1 : (m == 1) ? a - 1'b1 : a;
  endfunction

  task automatic model(input logic [AW-1:0] s, input logic [AW-1:0] d, input int n,
                       input int sm, input int dm);
    for (int k = 0; k < n; k++) begin
      exp_m[d] = exp_m[s];
      s = stp(s, sm);
      d = stp(d, dm);
    end
  endtask

  task automatic mem_init(input int seed);
    for (int i = 0; i < 256; i++) begin
      mem[i] = 32'h5A00_0000 ^ (i * 32'h0101_0013) ^ seed;
      exp_m[i] = mem[i];
    end
    nw = 0;
    for (int c = 0; c < NCH; c++) dk[c] = 0;
  endtask

  task automatic put(input int a, input logic [DW-1:0] v);
    mem[a] = v;
    exp_m[a] = v;
  endtask

  function automatic int mem_bad();
    mem_bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== exp_m[i]) mem_bad++;
  endfunction

  task automatic wr(input int ch, input int sel, input logic [DW-1:0] v);
    @(negedge clk);
    cfg_we = 1; cfg_ch = ch[1:0]; cfg_sel = sel[1:0]; cfg_wdata = v;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic wait_tc(input int ch);
    for (int i = 0; i < 3000 && !tc[ch]; i++) @(negedge clk);
  endtask

  initial begin
    for (int i = 0; i < 150000 && !done; i++) @(posedge clk);
    if (!done) begin
      runs++; fails++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("[TB] %0d tests run, %0d failed", runs, fails);
      $finish;
    end
  end

  initial begin
    for (int c = 0; c < NCH; c++) dk[c] = 0;
    mem_init(0);
    repeat (3) @(negedge clk);
    // R11 reset state
    chk(!m_req && tc == 0 && irq == 0 && dack == 0, "R11 reset", {m_req, irq, tc}, 0);
    rst_n = 1;
    @(negedge clk);

    // R3 R1 R8: sweep of address modes, memory-to-memory
    for (int sm = 0; sm < 3; sm++) begin
      for (int dm = 0; dm < 3; dm++) begin
        int ch = (sm * 3 + dm) % 4;
        int n = 2 + (sm + dm) % 4;
        bit ie = (sm + dm) % 2;
        logic [AW-1:0] sb = (sm == 1) ? 8'h17 : 8'h10;
        logic [AW-1:0] db = (dm == 1) ? 8'h47 : 8'h40;
        mem_init(sm * 16 + dm);
        model(sb, db, n, sm, dm);
        wr(ch, 1, sb); wr(ch, 2, db); wr(ch, 3, n);
        wr(ch, 0, ctl(1, sm, dm, 0, ie, 0));
        wait_tc(ch);
        @(negedge clk);
        chk(mem_bad() == 0, "R3 R2 mode sweep memory", mem_bad(), 0);
        chk(tc == (4'b1 << ch), "R8 tc set", tc, 4'b1 << ch);
        chk(irq == ie, "R8 irq enable", irq, ie);
        wr(ch, 0, ctl(0, 0, 0, 0, 0, 0));
        chk(tc == 0 && irq == 0, "R1 tc cleared by control write", tc, 0);
      end
    end

    // R4 zero count
    mem_init(99);
    wr(2, 3, 0);
    req_seen = 0;
    wr(2, 0, ctl(1, 0, 0, 0, 1, 0));
    repeat (4) @(negedge clk);
    chk(tc[2] == 1'b1 && irq, "R4 zero count tc", tc, 4);
    chk(!req_seen && mem_bad() == 0, "R4 zero count no bus access", req_seen, 0);
    wr(2, 0, 0);

    // R5 R9 peripheral-to-memory pacing, busy writes ignored
    mem_init(7);
    model(8'h20, 8'h50, 4, 0, 2);
    wr(1, 1, 8'h20); wr(1, 2, 8'h50); wr(1, 3, 4);
    wr(1, 0, ctl(1, 0, 2, 2, 0, 0));
    wr(1, 1, 8'h30); wr(1, 3, 9); wr(1, 2, 8'h90);
    req_seen = 0;
    repeat (40) @(negedge clk);
    chk(!req_seen && tc == 0, "R5 no unit without dreq", req_seen, 0);
    dreq[1] = 1;
    wait_tc(1);
    @(negedge clk);
    dreq[1] = 0;
    chk(mem_bad() == 0, "R9 busy writes ignored, R3 hold dest", mem_bad(), 0);
    chk(dk[1] == 4, "R5 dack per unit p2m", dk[1], 4);
    wr(1, 0, 0);

    // R5 memory-to-peripheral
    mem_init(11);
    model(8'h2F, 8'h60, 3, 1, 2);
    wr(3, 1, 8'h2F); wr(3, 2, 8'h60); wr(3, 3, 3);
    wr(3, 0, ctl(1, 1, 2, 1, 0, 0));
    req_seen = 0;
    repeat (30) @(negedge clk);
    chk(!req_seen, "R5 m2p waits for dreq", req_seen, 0);
    dreq[3] = 1;
    wait_tc(3);
    @(negedge clk);
    dreq[3] = 0;
    chk(mem_bad() == 0 && dk[3] == 3, "R5 m2p data and dack", dk[3], 3);
    wr(3, 0, 0);

    // R6 fixed priority on simultaneous release
    mem_init(21);
    model(8'h10, 8'h40, 3, 0, 0);
    model(8'h20, 8'h50, 3, 0, 0);
    wr(2, 1, 8'h20); wr(2, 2, 8'h50); wr(2, 3, 3); wr(2, 0, ctl(1, 0, 0, 2, 0, 0));
    wr(0, 1, 8'h10); wr(0, 2, 8'h40); wr(0, 3, 3); wr(0, 0, ctl(1, 0, 0, 2, 0, 0));
    nw = 0;
    dreq = 4'b0101;
    wait_tc(0); wait_tc(2);
    @(negedge clk);
    dreq = 0;
    chk(wlog[0] == 8'h40 && wlog[2] == 8'h42 && wlog[3] == 8'h50,
        "R6 channel 0 first", wlog[3], 8'h50);
    chk(mem_bad() == 0, "R6 both channels data", mem_bad(), 0);
    wr(0, 0, 0); wr(2, 0, 0);

    // R6 re-arbitration per unit
    mem_init(31);
    model(8'h20, 8'h50, 6, 0, 0);
    model(8'h10, 8'h40, 2, 0, 0);
    wr(0, 1, 8'h10); wr(0, 2, 8'h40); wr(0, 3, 2);
    wr(2, 1, 8'h20); wr(2, 2, 8'h50); wr(2, 3, 6);
    nw = 0;
    wr(2, 0, ctl(1, 0, 0, 0, 0, 0));
    wr(0, 0, ctl(1, 0, 0, 0, 0, 0));
    wait_tc(2); wait_tc(0);
    @(negedge clk);
    chk(wlog[7] == 8'h55, "R6 low channel preempts between units", wlog[7], 8'h55);
    chk(mem_bad() == 0, "R6 interleaved data", mem_bad(), 0);
    wr(0, 0, 0); wr(2, 0, 0);

    // R7 scatter-gather chain with zero-count descriptor
    mem_init(41);
    put(8'hC0, 8'h10); put(8'hC1, 8'h60); put(8'hC2, 3);
    put(8'hC3, ctl(0, 0, 0, 0, 0, 0)); put(8'hC4, 8'hC8);
    put(8'hC8, 8'h30); put(8'hC9, 8'h90); put(8'hCA, 0);
    put(8'hCB, 0); put(8'hCC, 8'hD0);
    put(8'hD0, 8'h23); put(8'hD1, 8'h70); put(8'hD2, 4);
    put(8'hD3, ctl(0, 1, 0, 0, 1, 0)); put(8'hD4, 0);
    model(8'h10, 8'h60, 3, 0, 0);
    model(8'h23, 8'h70, 4, 1, 0);
    wr(1, 1, 8'hC0);
    wr(1, 0, ctl(1, 0, 0, 0, 0, 1));
    wait_tc(1);
    @(negedge clk);
    chk(mem_bad() == 0, "R7 chain data", mem_bad(), 0);
    chk(tc == 4'b0010 && irq, "R7 R8 chain end tc and irq", tc, 2);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule